// File: doc/BRIEF.md
# Multi-Source Reset Controller with Sticky Cause Flags

This block merges reset requests from six causes into a single chip reset: power-on, brownout, an external active-low pin, watchdog, a software strobe and a UART break detector. Each cause has its own enable, and the pin has a dual role. While its reset function is off, the pin is an ordinary input whose synchronised level is offered to the general-purpose input logic. The chip reset rises as soon as any enabled request appears. It falls only after a fixed hold period, counted in clock cycles from the moment the last request goes away.

A six-bit cause register records which sources have fired since software last cleared them. Power-on loads it with a fixed pattern. Every other cause only adds its own bit. Software reads the register and clears bits by writing zeros to them.

The block also supplies the first fetch address. A boot status bit, together with the cause of the most recent reset, chooses between address zero and a page taken from an 8-bit boot vector. Power-on and brownout arrive as digital signals; level detection happens elsewhere.

Top module: `rst_hub`

## Requirements
- R1: With `pin_en_cfg`=1, a low level on `pin_raw` drives `chip_rst` high once it has passed through the two-stage synchroniser, and it sets cause bit 2.
- R2: Outside the power-on phase and with `pin_en_cfg`=0, a low pin causes no reset. In that case `pin_gpio` follows `pin_raw` two clock edges later. Whenever the pin acts as a reset input, `pin_gpio` reads 1.
- R3: The power-on phase starts when `pwr_on` rises and ends at the first clock edge at which `chip_rst` is low. Throughout this phase a low pin holds the reset whatever `pin_en_cfg` says, and it does not set cause bit 2.
- R4: `chip_rst` rises in the same cycle as any enabled request, with no clock edge needed. After the last request falls, it stays high through 4 more rising edges and goes low after the 4th.
- R5: The watchdog request is gated by `wdg_en_cfg`, the break request by `brk_en_cfg`, and the brownout request is dropped while `brn_off_cfg`=1. A request that is gated off neither resets nor sets its cause bit.
- R6: The cause bits are: 0 power-on, 1 brownout, 2 pin, 3 watchdog, 4 software, 5 break. `pwr_on` asynchronously loads the register with 6'b000011.
- R7: A reset from any cause other than power-on sets that cause's bit and leaves every other bit unchanged.
- R8: A write with `reg_wr`=1 clears each bit whose `reg_wdata` bit is 0 and leaves each bit whose `reg_wdata` bit is 1 as it was.
- R9: When a write and a cause event hit the same bit on the same edge, the bit ends up set.
- R10: A one-cycle `sw_rst_wr` pulse resets the chip and sets cause bit 4.
- R11: If the most recent reset was not a break reset, `start_addr` is 16'h0000 when `boot_stat`=0 and {`boot_vec`, 8'h00} when `boot_stat`=1.
- R12: After a break reset, `start_addr` is {`boot_vec`, 8'h00} whatever `boot_stat` says. Any later non-break reset, or a power-on, returns the choice to `boot_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_on | input | 1 | Power-on request, active high, asynchronous |
| pin_raw | input | 1 | External pin level, unsynchronised |
| brown_evt | input | 1 | Brownout request |
| wdg_evt | input | 1 | Watchdog request |
| brk_evt | input | 1 | UART break request |
| sw_rst_wr | input | 1 | Strobe for a write of 1 to the software reset bit |
| pin_en_cfg | input | 1 | Pin acts as a reset input when 1 |
| wdg_en_cfg | input | 1 | Watchdog reset enable |
| brk_en_cfg | input | 1 | Break reset enable |
| brn_off_cfg | input | 1 | Brownout reset disable |
| reg_wr | input | 1 | Cause register write strobe |
| reg_wdata | input | 6 | Cause register write data |
| reg_rdata | output | 6 | Cause register contents |
| boot_stat | input | 1 | Boot status bit |
| boot_vec | input | 8 | Boot vector, the high byte of the start address |
| chip_rst | output | 1 | Chip reset, active high |
| pin_gpio | output | 1 | Synchronised pin level for general-purpose input |
| start_addr | output | 16 | First fetch address |

## Verification
The assertions take for granted that every request other than `pwr_on` is synchronous to `clk` and is held across at least one rising edge. Without that, the hold counter and the cause register could miss a request that the asynchronous reset path has already reacted to. They also take for granted that `boot_vec` is stable around a break reset. The stimulus meets these conditions by changing inputs only on falling edges and by keeping the vector constant. It pulses `pwr_on` freely to exercise the asynchronous preset path.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
   localparam int SRC_N   = 6;
   localparam int IDX_PWR = 0;
   localparam int IDX_BRN = 1;
   localparam int IDX_PIN = 2;
   localparam int IDX_WDG = 3;
   localparam int IDX_SW  = 4;
   localparam int IDX_BRK = 5;

   typedef logic [SRC_N-1:0] src_vec_t;

   localparam src_vec_t POR_PRESET = src_vec_t'((1 << IDX_PWR) | (1 << IDX_BRN));
endpackage

// File: rtl/rst_hub_sync.sv
module rst_hub_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("rst_hub_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or posedge arst) begin
            if (arst) chain <= RST_VAL;
            else      chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or posedge arst) begin
            if (arst) chain <= {STAGES{RST_VAL}};
            else      chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_hub_stretch.sv
module rst_hub_stretch #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic por,
   input  logic load,
   output logic rst_out
);
   localparam int CW = $clog2(HOLD + 1);

   logic [CW-1:0] cnt;

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("rst_hub_stretch: HOLD must be at least 2");
      end
   endgenerate

   // the counter is reloaded for as long as any request is present
   always_ff @(posedge clk or posedge load) begin
      if (load)              cnt <= CW'(HOLD);
      else if (cnt != '0)    cnt <= cnt - CW'(1);
   end

   assign rst_out = load | (cnt != '0);

   // R4: the cycle after the requests drop, the reset is still held
   p_hold_after_drop_r4: assert property (@(posedge clk) disable iff (por)
      $fell(load) |-> rst_out);

   // R4: once released, reset comes back only with a new request
   p_no_spurious_r4: assert property (@(posedge clk) disable iff (por)
      !rst_out |=> (!rst_out || load));
endmodule

// File: rtl/rst_hub_flags.sv
module rst_hub_flags import rst_hub_pkg::*; #(
   parameter int N = SRC_N
) (
   input  logic         clk,
   input  logic         por,
   input  logic         wr_en,
   input  logic [N-1:0] wdata,
   input  logic [N-1:0] set_vec,
   output logic [N-1:0] flags
);
   localparam logic [N-1:0] PRESET = N'(POR_PRESET);

   generate
      if (N != SRC_N) begin : g_bad_width
         $error("rst_hub_flags: N must equal the number of sources");
      end
   endgenerate

   logic [N-1:0] kept;

   assign kept = wr_en ? (flags & wdata) : flags;

   always_ff @(posedge clk or posedge por) begin
      if (por) flags <= PRESET;
      else     flags <= kept | set_vec;
   end

   // R9: a bit being set on this edge is set afterwards, write or not
   p_set_wins_r9: assert property (@(posedge clk) disable iff (por)
      (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

   // R8: a write with no event clears exactly the zero positions
   p_clear_r8: assert property (@(posedge clk) disable iff (por)
      (wr_en && !(|set_vec)) |=> (flags == ($past(flags) & $past(wdata))));

   // R7: without a write, no bit is ever lost
   p_accum_r7: assert property (@(posedge clk) disable iff (por)
      !wr_en |=> (($past(flags) & ~flags) == '0));
endmodule

// File: rtl/rst_hub_boot.sv
module rst_hub_boot #(
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              por,
   input  logic              brk_hit,
   input  logic              any_hit,
   input  logic              boot_stat,
   input  logic [VEC_W-1:0]  boot_vec,
   output logic [ADDR_W-1:0] start_addr
);
   localparam int LOW_W = ADDR_W - VEC_W;

   logic last_brk;
   logic use_vec;

   generate
      if (LOW_W < 1) begin : g_bad_addr
         $error("rst_hub_boot: ADDR_W must exceed VEC_W");
      end
   endgenerate

   always_ff @(posedge clk or posedge por) begin
      if (por)          last_brk <= 1'b0;
      else if (brk_hit) last_brk <= 1'b1;
      else if (any_hit) last_brk <= 1'b0;
   end

   assign use_vec    = boot_stat | last_brk;
   assign start_addr = use_vec ? {boot_vec, {LOW_W{1'b0}}} : '0;

   // R12: a break reset selects the vector page on the following cycle
   p_brk_vec_r12: assert property (@(posedge clk) disable iff (por)
      brk_hit |=> (start_addr[ADDR_W-1 -: VEC_W] == boot_vec));
endmodule

// File: rtl/rst_hub.sv
module rst_hub import rst_hub_pkg::*; #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 4,
   parameter int VEC_W       = 8,
   parameter int ADDR_W      = 16
) (
   input  logic              clk,
   input  logic              pwr_on,
   input  logic              pin_raw,
   input  logic              brown_evt,
   input  logic              wdg_evt,
   input  logic              brk_evt,
   input  logic              sw_rst_wr,
   input  logic              pin_en_cfg,
   input  logic              wdg_en_cfg,
   input  logic              brk_en_cfg,
   input  logic              brn_off_cfg,
   input  logic              reg_wr,
   input  logic [SRC_N-1:0]  reg_wdata,
   output logic [SRC_N-1:0]  reg_rdata,
   input  logic              boot_stat,
   input  logic [VEC_W-1:0]  boot_vec,
   output logic              chip_rst,
   output logic              pin_gpio,
   output logic [ADDR_W-1:0] start_addr
);
   logic       pin_sync;
   logic       por_phase;
   logic       pin_active;
   logic       req_pin, req_brn, req_wdg, req_brk, req_sw;
   logic       req_load;
   logic       req_other;
   src_vec_t   set_vec;

   rst_hub_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk  (clk),
      .arst (pwr_on),
      .d    (pin_raw),
      .q    (pin_sync)
   );

   // power-on phase: from pwr_on until the first edge with reset released
   always_ff @(posedge clk or posedge pwr_on) begin
      if (pwr_on)         por_phase <= 1'b1;
      else if (!chip_rst) por_phase <= 1'b0;
   end

   assign pin_active = por_phase | pin_en_cfg;
   assign req_pin    = pin_active & ~pin_sync;
   assign req_brn    = brown_evt & ~brn_off_cfg;
   assign req_wdg    = wdg_evt & wdg_en_cfg;
   assign req_brk    = brk_evt & brk_en_cfg;
   assign req_sw     = sw_rst_wr;
   assign req_other  = req_pin | req_brn | req_wdg | req_brk | req_sw;
   assign req_load   = pwr_on | req_other;

   always_comb begin
      set_vec          = '0;
      set_vec[IDX_BRN] = req_brn;
      set_vec[IDX_PIN] = req_pin & ~por_phase;
      set_vec[IDX_WDG] = req_wdg;
      set_vec[IDX_SW]  = req_sw;
      set_vec[IDX_BRK] = req_brk;
   end

   rst_hub_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
      .clk     (clk),
      .por     (pwr_on),
      .load    (req_load),
      .rst_out (chip_rst)
   );

   rst_hub_flags #(.N(SRC_N)) u_flags (
      .clk     (clk),
      .por     (pwr_on),
      .wr_en   (reg_wr),
      .wdata   (reg_wdata),
      .set_vec (set_vec),
      .flags   (reg_rdata)
   );

   rst_hub_boot #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_boot (
      .clk        (clk),
      .por        (pwr_on),
      .brk_hit    (req_brk),
      .any_hit    (req_other),
      .boot_stat  (boot_stat),
      .boot_vec   (boot_vec),
      .start_addr (start_addr)
   );

   assign pin_gpio = pin_active ? 1'b1 : pin_sync;

   // R2: a disabled pin outside power-on never produces a cause bit
   p_pin_quiet_r2: assert property (@(posedge clk) disable iff (pwr_on)
      (!pin_en_cfg && !por_phase && !reg_wr) |=> ($past(reg_rdata[IDX_PIN]) == reg_rdata[IDX_PIN]));

   // R3: while in the power-on phase a low pin keeps the chip in reset
   p_por_pin_r3: assert property (@(posedge clk) disable iff (pwr_on)
      (por_phase && !pin_sync) |-> chip_rst);
endmodule

// File: tb/rst_hub_bench.sv
module rst_hub_bench;
   localparam int CLK_P = 10;
   localparam int HOLD  = 4;

   logic       clk = 1'b0;
   logic       pwr_on, pin_raw, brown_evt, wdg_evt, brk_evt, sw_rst_wr;
   logic       pin_en_cfg, wdg_en_cfg, brk_en_cfg, brn_off_cfg;
   logic       reg_wr;
   logic [5:0] reg_wdata, reg_rdata;
   logic       boot_stat;
   logic [7:0] boot_vec;
   logic       chip_rst, pin_gpio;
   logic [15:0] start_addr;

   int checks = 0;
   int bad    = 0;
   int cycle  = 0;

   always #(CLK_P/2) clk = ~clk;

   rst_hub u_rst_hub (
      .clk(clk), .pwr_on(pwr_on), .pin_raw(pin_raw), .brown_evt(brown_evt),
      .wdg_evt(wdg_evt), .brk_evt(brk_evt), .sw_rst_wr(sw_rst_wr),
      .pin_en_cfg(pin_en_cfg), .wdg_en_cfg(wdg_en_cfg), .brk_en_cfg(brk_en_cfg),
      .brn_off_cfg(brn_off_cfg), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .boot_stat(boot_stat), .boot_vec(boot_vec),
      .chip_rst(chip_rst), .pin_gpio(pin_gpio), .start_addr(start_addr)
   );

   // behavioural reference state
   int       m_cnt = HOLD;
   bit       m_por = 1'b1;
   bit       m_s1 = 1'b1, m_s2 = 1'b1;
   bit [5:0] m_fl = 6'b000011;
   bit       m_brk = 1'b0;

   function automatic bit any_req(bit por, bit s2);
      return ((por | pin_en_cfg) & !s2) | (brown_evt & !brn_off_cfg) |
             (wdg_evt & wdg_en_cfg) | (brk_evt & brk_en_cfg) | sw_rst_wr;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycle, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycle++;
      if (pwr_on) begin
         m_cnt = HOLD; m_por = 1; m_s1 = 1; m_s2 = 1; m_fl = 6'b000011; m_brk = 0;
      end else begin
         bit a_old;
         bit [5:0] setv;
         bit b_req;
         a_old = any_req(m_por, m_s2);
         b_req = brk_evt & brk_en_cfg;
         setv = {b_req, sw_rst_wr, wdg_evt & wdg_en_cfg,
                 (pin_en_cfg | m_por) & !m_s2 & !m_por, brown_evt & !brn_off_cfg, 1'b0};
         m_fl = (reg_wr ? (m_fl & reg_wdata) : m_fl) | setv;
         if (b_req) m_brk = 1; else if (a_old) m_brk = 0;
         if (!a_old && m_cnt == 0) m_por = 0;
         if (a_old) m_cnt = HOLD; else if (m_cnt > 0) m_cnt--;
         m_s2 = m_s1; m_s1 = pin_raw;
         if (any_req(m_por, m_s2)) m_cnt = HOLD;
      end
      #2;
      chk("R4 chip_rst", chip_rst, (pwr_on | any_req(m_por, m_s2) | (m_cnt != 0)) ? 1 : 0);
      chk("R7 cause register", reg_rdata, m_fl);
      chk("R2 pin_gpio", pin_gpio, (m_por | pin_en_cfg) ? 1 : m_s2);
      chk("R11 start_addr", start_addr, (boot_stat | m_brk) ? {boot_vec, 8'h00} : 16'h0);
   end

   task automatic ticks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_flags(logic [5:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      ticks(1);
      reg_wr = 1'b0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      #(CLK_P * 5000);
      bad++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finish_run();
   end

   initial begin
      pwr_on = 1; pin_raw = 0; brown_evt = 0; wdg_evt = 0; brk_evt = 0; sw_rst_wr = 0;
      pin_en_cfg = 0; wdg_en_cfg = 1; brk_en_cfg = 1; brn_off_cfg = 0;
      reg_wr = 0; reg_wdata = 0; boot_stat = 0; boot_vec = 8'hA5;
      ticks(3);
      chk("R6 reset state chip_rst", chip_rst, 1);
      chk("R6 power-on preset", reg_rdata, 6'b000011);
      chk("R11 boot_stat=0 address", start_addr, 16'h0000);

      // R3: pin held low after power-on keeps reset despite pin_en_cfg=0
      pwr_on = 0;
      ticks(10);
      chk("R3 pin holds reset in power-on", chip_rst, 1);
      pin_raw = 1;
      ticks(2 + HOLD + 2);
      chk("R3 released", chip_rst, 0);
      chk("R3 no pin cause", reg_rdata, 6'b000011);

      // R2: pin as plain input
      pin_raw = 0;
      ticks(5);
      chk("R2 no reset from disabled pin", chip_rst, 0);
      chk("R2 gpio low", pin_gpio, 0);
      pin_raw = 1;
      ticks(3);
      chk("R2 gpio high", pin_gpio, 1);

      // R8: clear power-on bit only, then everything
      write_flags(6'b111110);
      chk("R8 clear bit 0", reg_rdata, 6'b000010);
      write_flags(6'b000000);
      chk("R8 clear all", reg_rdata, 6'b000000);

      // R1: pin as reset input
      pin_en_cfg = 1;
      ticks(1);
      chk("R1 gpio reads 1 when pin is reset", pin_gpio, 1);
      pin_raw = 0;
      ticks(3);
      chk("R1 pin reset", chip_rst, 1);
      chk("R1 pin cause", reg_rdata, 6'b000100);
      pin_raw = 1;
      ticks(10);
      chk("R1 released", chip_rst, 0);
      pin_en_cfg = 0;
      write_flags(6'b000000);

      // R4: asynchronous assertion and hold count
      wdg_evt = 1;
      #1;
      chk("R4 async assert", chip_rst, 1);
      ticks(1);
      wdg_evt = 0;
      ticks(3);
      chk("R4 held after 3 edges", chip_rst, 1);
      ticks(1);
      chk("R4 low after 4 edges", chip_rst, 0);
      chk("R7 watchdog cause", reg_rdata, 6'b001000);

      // R5: gated sources
      wdg_en_cfg = 0; wdg_evt = 1;
      ticks(2);
      wdg_evt = 0;
      chk("R5 watchdog gated", chip_rst, 0);
      brn_off_cfg = 1; brown_evt = 1;
      ticks(2);
      brown_evt = 0;
      chk("R5 brownout gated", chip_rst, 0);
      brk_en_cfg = 0; brk_evt = 1;
      ticks(2);
      brk_evt = 0;
      chk("R5 break gated", chip_rst, 0);
      chk("R5 no causes from gated sources", reg_rdata, 6'b001000);
      brn_off_cfg = 0; brown_evt = 1;
      ticks(1);
      brown_evt = 0;
      ticks(HOLD + 1);
      chk("R7 brownout accumulates", reg_rdata, 6'b001010);

      // R10 and R9: software reset while clearing everything
      sw_rst_wr = 1; reg_wr = 1; reg_wdata = 6'b000000;
      #1;
      chk("R10 software reset asserts", chip_rst, 1);
      ticks(1);
      sw_rst_wr = 0; reg_wr = 0;
      chk("R9 set wins over clear", reg_rdata, 6'b010000);
      ticks(HOLD + 1);

      // R12: break reset selects vector page
      brk_en_cfg = 1; brk_evt = 1;
      ticks(1);
      brk_evt = 0;
      ticks(HOLD + 1);
      chk("R12 break selects vector", start_addr, 16'hA500);
      chk("R7 break cause", reg_rdata, 6'b110000);
      wdg_en_cfg = 1; wdg_evt = 1;
      ticks(1);
      wdg_evt = 0;
      ticks(HOLD + 1);
      chk("R12 later reset returns to boot_stat", start_addr, 16'h0000);
      boot_stat = 1;
      ticks(1);
      chk("R11 boot_stat=1 address", start_addr, 16'hA500);

      // power-on again presets
      pwr_on = 1;
      ticks(2);
      pwr_on = 0;
      ticks(4 + HOLD);
      chk("R6 second power-on preset", reg_rdata, 6'b000011);
      ticks(2);
      finish_run();
   end
endmodule